// File: doc/BRIEF.md
# Interrupt Status Register with Read-to-Clear

This block gathers single-cycle event pulses from a network MAC into a seven-bit interrupt status register. The events are transmit done, receive done, three counter-overflow events (missed frames, runt frames, receive collisions), a missing transceiver test pulse after transmit (collision error), and an over-long transmit (babble). The event logic lives elsewhere. Each event has a mask bit. A single active-low interrupt line goes low while any set status bit has its mask bit at 0.

The host uses a simple strobe interface with two registers. Status is at address 0 and mask is at address 1. Read data is combinational from the current register state. A strobed status read clears the register on the same clock edge. An event that lands in the same cycle as that read is kept, so the next read reports it. The host cannot change status bits by writing. Both the external reset and a software reset strobe clear the status bits. The mask resets to all ones, so every source starts masked.

Top module: `irq_status_reg`

## Requirements
- R1: At address 0, bit 0 is transmit done, bit 1 receive done, bit 2 missed-frame count overflow, bit 3 runt count overflow, bit 4 receive-collision count overflow, bit 5 collision error, bit 6 babble, and bit 7 always reads 0. Event input ev_i[n] feeds status bit n. The mask at address 1 uses the same bit positions.
- R2: A 1 on ev_i[n] at a clock edge sets status bit n, and the bit holds until it is cleared.
- R3: With rd_i high and addr_i at 0, rdata_o shows the current status, and every status bit with no event in that cycle is 0 after the edge.
- R4: An event in the same cycle as a status read shows the bit's old value in rdata_o, and the bit is 1 after the edge.
- R5: A write to address 0 leaves every status bit unchanged.
- R6: While rst_n is low, the status reads 0x00, the mask reads 0xFF and irq_n_o is 1.
- R7: soft_rst_i high at an edge clears all status bits, even when an event arrives in the same cycle, and leaves the mask unchanged.
- R8: A write to address 1 loads all eight wdata_i bits into the mask on that edge. Reading the mask clears nothing.
- R9: irq_n_o is a register that is 0 exactly when some status bit n is 1 with mask bit n at 0. It changes on the same edge as the status and mask registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_rst_i | input | 1 | Software reset strobe, clears status bits |
| ev_i | input | 7 | Event pulses, one per status bit |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 1 | Register select: 0 status, 1 mask |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| irq_n_o | output | 1 | Registered active-low interrupt |

## Verification
The assertions take for granted that every input changes only between clock edges and is stable at the edge. They also assume that read and write strobes are single-cycle and carry a meaningful address whenever either strobe is high. The stimulus drives all inputs on the falling edge. It draws each event bit and strobe from a seeded random source, with rates kept low enough that set bits often survive to a later read. The directed cases place an event on the same edge as a read, as a status write and as a soft reset.

// File: rtl/irq_stat_pkg.sv
`timescale 1ns/1ps
package irq_stat_pkg;
  localparam int unsigned SRC_N   = 7;
  localparam int unsigned REG_W   = 8;

  // status bit positions (the host decodes these)
  localparam int unsigned BIT_TX_DONE  = 0;
  localparam int unsigned BIT_RX_DONE  = 1;
  localparam int unsigned BIT_MISS_OVF = 2;
  localparam int unsigned BIT_RUNT_OVF = 3;
  localparam int unsigned BIT_RCOL_OVF = 4;
  localparam int unsigned BIT_COL_ERR  = 5;
  localparam int unsigned BIT_BABBLE   = 6;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
`timescale 1ns/1ps
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_stat_cell.sv
`timescale 1ns/1ps
module irq_stat_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic bit_d,
  output logic bit_q
);
  // priority: soft reset, then event, then read-clear
  always_comb begin
    bit_d = bit_q;
    if (srst_i)     bit_d = 1'b0;
    else if (set_i) bit_d = 1'b1;
    else if (clr_i) bit_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= bit_d;
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !srst_i) |=> bit_q);

  assert_read_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i && !srst_i) |=> !bit_q);

  assert_event_beats_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i && !srst_i) |=> bit_q);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i && !srst_i) |=> $stable(bit_q));

  assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> !bit_q);
endmodule

// File: rtl/irq_mask_reg.sv
`timescale 1ns/1ps
module irq_mask_reg #(
  parameter int unsigned REG_W = 8,
  parameter int unsigned SRC_N = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [SRC_N-1:0] src_mask_d,
  output logic [REG_W-1:0] mask_q
);
  logic [REG_W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (we_i) mask_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_d;
  end

  assign src_mask_d = mask_d[SRC_N-1:0];

  assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mask_q == $past(wdata_i)));

  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mask_q));
endmodule

// File: rtl/irq_out_drv.sv
`timescale 1ns/1ps
module irq_out_drv #(
  parameter int unsigned SRC_N = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] stat_d,
  input  logic [SRC_N-1:0] mask_d,
  output logic             irq_n_o
);
  logic pend_d;

  assign pend_d = |(stat_d & ~mask_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n_o <= 1'b1;
    else        irq_n_o <= ~pend_d;
  end
endmodule

// File: rtl/irq_status_reg.sv
`timescale 1ns/1ps
module irq_status_reg #(
  parameter int unsigned REG_W = irq_stat_pkg::REG_W,
  parameter int unsigned SRC_N = irq_stat_pkg::SRC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst_i,
  input  logic [SRC_N-1:0] ev_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_n_o
);
  import irq_stat_pkg::*;

  localparam int unsigned PAD_W = REG_W - SRC_N;

  logic             rst_n_s;
  logic             rd_stat;
  logic             wr_mask;
  logic [SRC_N-1:0] stat_d;
  logic [SRC_N-1:0] stat_q;
  logic [SRC_N-1:0] src_mask_d;
  logic [REG_W-1:0] mask_q;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign rd_stat = rd_i && (reg_sel_e'(addr_i) == SEL_STATUS);
  assign wr_mask = wr_i && (reg_sel_e'(addr_i) == SEL_MASK);

  for (genvar n = 0; n < SRC_N; n++) begin : g_bit
    irq_stat_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .srst_i (soft_rst_i),
      .set_i  (ev_i[n]),
      .clr_i  (rd_stat),
      .bit_d  (stat_d[n]),
      .bit_q  (stat_q[n])
    );
  end

  irq_mask_reg #(.REG_W(REG_W), .SRC_N(SRC_N)) u_mask (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .we_i       (wr_mask),
    .wdata_i    (wdata_i),
    .src_mask_d (src_mask_d),
    .mask_q     (mask_q)
  );

  irq_out_drv #(.SRC_N(SRC_N)) u_out (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .stat_d  (stat_d),
    .mask_d  (src_mask_d),
    .irq_n_o (irq_n_o)
  );

  always_comb begin
    if (reg_sel_e'(addr_i) == SEL_STATUS) rdata_o = {{PAD_W{1'b0}}, stat_q};
    else                                  rdata_o = mask_q;
  end

  assert_irq_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_n_o == ~|(stat_q & ~mask_q[SRC_N-1:0]));

  assert_top_bits_zero_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_stat |-> (rdata_o[REG_W-1:SRC_N] == '0));

  assert_status_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_i && !addr_i && !rd_i && !soft_rst_i && ev_i == '0) |=> $stable(stat_q));
endmodule

// File: tb/irq_status_reg_tb_top.sv
`timescale 1ns/1ps
module irq_status_reg_tb_top;
  logic       clk;
  logic       rst_n;
  logic       soft_rst_i;
  logic [6:0] ev_i;
  logic       rd_i;
  logic       wr_i;
  logic       addr_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o;
  logic       irq_n_o;

  int n_chk  = 0;
  int n_fail = 0;

  logic [6:0] m_stat;
  logic [7:0] m_mask;

  irq_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .ev_i(ev_i),
    .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_n_o(irq_n_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [6:0] f_next_stat(logic [6:0] s, logic [6:0] ev,
                                             logic rd_s, logic sr);
    if (sr) return 7'h00;
    return (rd_s ? 7'h00 : s) | ev;
  endfunction

  function automatic logic f_irq_n(logic [6:0] s, logic [7:0] m);
    return ~|(s & ~m[6:0]);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic step(logic [6:0] ev, logic rd, logic wr, logic a,
                      logic [7:0] wd, logic sr, string tag);
    ev_i = ev; rd_i = rd; wr_i = wr; addr_i = a; wdata_i = wd; soft_rst_i = sr;
    #1;
    if (rd) chk(tag, rdata_o, a ? m_mask : {1'b0, m_stat});
    m_stat = f_next_stat(m_stat, ev, rd && !a, sr);
    if (wr && a) m_mask = wd;
    @(posedge clk); #1;
    chk({tag, " irq"}, {7'h0, irq_n_o}, {7'h0, f_irq_n(m_stat, m_mask)});
    ev_i = '0; rd_i = 0; wr_i = 0; soft_rst_i = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL R9: watchdog expired actual 0 expected 1");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; soft_rst_i = 0; ev_i = 0; rd_i = 0; wr_i = 0; addr_i = 0; wdata_i = 0;
    m_stat = '0; m_mask = 8'hFF;
    repeat (3) @(negedge clk);
    // R6 reset state
    addr_i = 0; #1 chk("R6 status", rdata_o, 8'h00);
    addr_i = 1; #1 chk("R6 mask", rdata_o, 8'hFF);
    chk("R6 irq", {7'h0, irq_n_o}, 8'h01);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1/R2: each source alone, masked out, then read
    for (int b = 0; b < 7; b++) begin
      step(7'h01 << b, 0, 0, 0, 8'h0, 0, "R2");
      step(7'h00, 1, 0, 0, 8'h0, 0, "R1");
    end
    step(7'h00, 1, 0, 0, 8'h0, 0, "R3");
    // R8: unmask bits and read mask back
    step(7'h00, 0, 1, 1, 8'hA5, 0, "R8");
    step(7'h00, 1, 0, 1, 8'h0, 0, "R8");
    step(7'h00, 1, 0, 1, 8'h0, 0, "R8");
    // R9: unmasked bit 1 drives interrupt
    step(7'h02, 0, 0, 0, 8'h0, 0, "R9");
    // R4: event on same cycle as read
    step(7'h08, 1, 0, 0, 8'h0, 0, "R4");
    step(7'h00, 1, 0, 0, 8'h0, 0, "R4");
    step(7'h00, 1, 0, 0, 8'h0, 0, "R3");
    // R5: status write ignored
    step(7'h10, 0, 0, 0, 8'h0, 0, "R5");
    step(7'h00, 0, 1, 0, 8'h7F, 0, "R5");
    step(7'h00, 0, 1, 0, 8'h00, 0, "R5");
    step(7'h00, 1, 0, 0, 8'h0, 0, "R5");
    // R7: soft reset beats event, keeps mask
    step(7'h21, 0, 0, 0, 8'h0, 0, "R7");
    step(7'h40, 0, 0, 0, 8'h0, 1, "R7");
    step(7'h00, 1, 0, 0, 8'h0, 0, "R7");
    step(7'h00, 1, 0, 1, 8'h0, 0, "R7");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] ev;
      for (int b = 0; b < 7; b++) ev[b] = ($urandom % 12) == 0;
      step(ev, ($urandom % 5) == 0, ($urandom % 6) == 0, $urandom % 2,
           8'($urandom), ($urandom % 50) == 0, "R3");
    end

    // R6: reset in mid-run
    step(7'h7F, 0, 1, 1, 8'h00, 0, "R6");
    rst_n = 0; #1;
    chk("R6 irq", {7'h0, irq_n_o}, 8'h01);
    m_stat = '0; m_mask = 8'hFF;
    addr_i = 0; #1 chk("R6 status", rdata_o, 8'h00);
    addr_i = 1; #1 chk("R6 mask", rdata_o, 8'hFF);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    step(7'h00, 1, 0, 0, 8'h0, 0, "R6");
    finish_run();
  end
endmodule